// File: doc/BRIEF.md
# Trap Entry Controller

This block performs the architectural state change a hart makes when it takes an exception or an interrupt. A trap request arrives as a one-cycle strobe. It carries an interrupt flag, a cause code and a faulting address. With it the block samples the trapping PC, the current privilege, the status word, both delegation masks and both trap vector bases. On the next clock edge it commits every update at once. That covers the next PC, the new privilege, the rewritten status word, and the program counter, cause and trap-value registers of whichever bank handles the trap.

The environment-call cause is corrected by the privilege it came from. The delegation mask that applies is selected by the interrupt flag. The trap-value register is written only for causes that carry an address. The block holds its own copies of the supervisor and machine trap registers, the privilege and the PC. It returns the status word as an output, so that the surrounding core can store it back.

Top module: `trap_entry`

## Requirements
- R1: Reset state: privilege is machine (2'b11), the PC equals the parameter RESET_PC, the status output and all six trap registers are zero, and trap_done is low.
- R2: The written cause value has bit XLEN-1 equal to the interrupt flag and the corrected cause code in its low CODE_W bits, with zeros in between.
- R3: A non-interrupt request with code 8 is recorded as code 8 plus the current privilege: 8 from user (0), 9 from supervisor (1), 11 from machine (3). All other codes pass through unchanged.
- R4: Interrupts look up the interrupt delegation mask and exceptions look up the exception delegation mask. The bit used is the one indexed by the corrected code.
- R5: The trap goes to supervisor (1) only when the current privilege is 0 or 1 and the selected delegation bit is 1. Otherwise it goes to machine (3).
- R6: On supervisor entry: the PC becomes stvec, sepc gets the trapping PC and scause gets the cause. Status bit 5 takes the old bit 1, bit 8 takes bit 0 of the old privilege, and bit 1 is cleared. The machine registers are not changed.
- R7: On machine entry: the PC becomes mtvec, mepc gets the trapping PC and mcause gets the cause. Status bit 7 takes the old bit 3, bits 12:11 take the old privilege, and bit 3 is cleared. The supervisor registers are not changed.
- R8: The handling bank's trap-value register is loaded with the faulting address only for exceptions with corrected code 0, 1, 4, 5, 6, 7, 12, 13 or 15. Otherwise it keeps its value.
- R9: Status bits other than the stack fields of the chosen bank are copied from the status input.
- R10: All updates appear on the clock edge that samples trap_valid high. trap_done is high for exactly the following cycle. While trap_valid is low, no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request strobe |
| trap_is_irq | input | 1 | Request is an interrupt |
| trap_code | input | CODE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege |
| status_i | input | XLEN | Current status word |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| mtvec_i | input | XLEN | Machine trap vector base |
| stvec_i | input | XLEN | Supervisor trap vector base |
| pc_o | output | XLEN | Next PC |
| priv_o | output | 2 | Privilege after the trap |
| status_o | output | XLEN | Updated status word |
| sepc_o | output | XLEN | Supervisor exception PC |
| scause_o | output | XLEN | Supervisor cause |
| stval_o | output | XLEN | Supervisor trap value |
| mepc_o | output | XLEN | Machine exception PC |
| mcause_o | output | XLEN | Machine cause |
| mtval_o | output | XLEN | Machine trap value |
| trap_done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every privilege (0, 1, 3), both trap kinds and codes 0 to 15 and 31, under complementary delegation masks, and predicts every output from its own model of all registers. Each corner case maps to a specific failure:
- Environment call from each privilege: a design that skipped the cause correction would record 8 everywhere.
- Traps from machine mode with the delegation bit set: a design that ignored the privilege would wrongly enter supervisor.
- Interrupts under a mask that differs from the exception mask: a design that swapped the masks would route to the wrong bank.
- Non-address causes: a design that always wrote the trap value would clobber the stored address.

Between traps the bench scrambles every input with trap_valid low, which exposes a design that updates its registers while idle.

// File: rtl/trap_entry.sv
module trap_entry #(
  parameter int XLEN = 32,
  parameter int CODE_W = 5,
  parameter logic [XLEN-1:0] RESET_PC = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_addr,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [1:0]        cur_priv,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   medeleg_i,
  input  logic [XLEN-1:0]   mideleg_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [XLEN-1:0]   stvec_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [1:0]        priv_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mtval_o,
  output logic              trap_done
);
  localparam int SIE_B = 1, MIE_B = 3, SPIE_B = 5, MPIE_B = 7, SPP_B = 8, MPP_LO = 11;
  localparam logic [15:0] ADDR_CAUSES = 16'b1011_0000_1111_0011;
  localparam logic [CODE_W-1:0] ECALL_CODE = CODE_W'(8);

  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   deleg_sel, cause_val, status_nx;
  logic              to_super, tval_hit;

  assign eff_code  = (!trap_is_irq && trap_code == ECALL_CODE)
                     ? ECALL_CODE + CODE_W'(cur_priv) : trap_code;
  assign deleg_sel = trap_is_irq ? mideleg_i : medeleg_i;
  assign to_super  = (cur_priv <= 2'd1) && deleg_sel[eff_code];
  assign cause_val = {trap_is_irq, {(XLEN-1-CODE_W){1'b0}}, eff_code};
  assign tval_hit  = !trap_is_irq && (eff_code < CODE_W'(16)) && ADDR_CAUSES[eff_code[3:0]];

  always_comb begin
    status_nx = status_i;
    if (to_super) begin
      status_nx[SPIE_B] = status_i[SIE_B];
      status_nx[SPP_B]  = cur_priv[0];
      status_nx[SIE_B]  = 1'b0;
    end else begin
      status_nx[MPIE_B]           = status_i[MIE_B];
      status_nx[MPP_LO+1:MPP_LO]  = cur_priv;
      status_nx[MIE_B]            = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o      <= RESET_PC;
      priv_o    <= 2'd3;
      status_o  <= '0;
      sepc_o    <= '0;
      scause_o  <= '0;
      stval_o   <= '0;
      mepc_o    <= '0;
      mcause_o  <= '0;
      mtval_o   <= '0;
      trap_done <= 1'b0;
    end else begin
      trap_done <= trap_valid;
      if (trap_valid) begin
        status_o <= status_nx;
        if (to_super) begin
          pc_o     <= stvec_i;
          priv_o   <= 2'd1;
          sepc_o   <= cur_pc;
          scause_o <= cause_val;
          if (tval_hit) stval_o <= trap_addr;
        end else begin
          pc_o     <= mtvec_i;
          priv_o   <= 2'd3;
          mepc_o   <= cur_pc;
          mcause_o <= cause_val;
          if (tval_hit) mtval_o <= trap_addr;
        end
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic            trap_is_irq,
  input logic [1:0]      cur_priv,
  input logic [XLEN-1:0] mtvec_i,
  input logic [XLEN-1:0] stvec_i,
  input logic [XLEN-1:0] pc_o,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] scause_o,
  input logic [XLEN-1:0] mcause_o,
  input logic            trap_done
);
  // R10
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> trap_done);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> ($stable(pc_o) && $stable(priv_o) && $stable(status_o) && !trap_done));
  // R5
  priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (priv_o == 2'd1 || priv_o == 2'd3));
  // R7
  mach_from_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_priv == 2'd3) |=> (priv_o == 2'd3 && pc_o == $past(mtvec_i) && !status_o[3]));
  // R6
  sup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (priv_o != 2'd1 ||
      (pc_o == $past(stvec_i) && !status_o[1] && status_o[8] == $past(cur_priv[0]))));
  // R2
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((priv_o == 2'd3) ? mcause_o[XLEN-1] == $past(trap_is_irq)
                                     : scause_o[XLEN-1] == $past(trap_is_irq)));
endmodule

bind trap_entry trap_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trap_entry_bench.sv
`timescale 1ns/1ps
module trap_entry_bench;
  localparam int XLEN = 32;
  localparam int CODE_W = 5;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic trap_valid = 0, trap_is_irq = 0;
  logic [CODE_W-1:0] trap_code = '0;
  logic [31:0] trap_addr = '0, cur_pc = '0, status_i = '0, medeleg_i = '0, mideleg_i = '0;
  logic [31:0] mtvec_i = '0, stvec_i = '0;
  logic [1:0]  cur_priv = '0;
  logic [31:0] pc_o, status_o, sepc_o, scause_o, stval_o, mepc_o, mcause_o, mtval_o;
  logic [1:0]  priv_o;
  logic        trap_done;

  int total = 0, bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] e_pc, e_status, e_sepc, e_scause, e_stval, e_mepc, e_mcause, e_mtval;
  logic [1:0]  e_priv;

  always #4 clk = ~clk;

  trap_entry #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_PC(RST_PC)) u_trap_entry (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
    .trap_code(trap_code), .trap_addr(trap_addr), .cur_pc(cur_pc), .cur_priv(cur_priv),
    .status_i(status_i), .medeleg_i(medeleg_i), .mideleg_i(mideleg_i),
    .mtvec_i(mtvec_i), .stvec_i(stvec_i), .pc_o(pc_o), .priv_o(priv_o),
    .status_o(status_o), .sepc_o(sepc_o), .scause_o(scause_o), .stval_o(stval_o),
    .mepc_o(mepc_o), .mcause_o(mcause_o), .mtval_o(mtval_o), .trap_done(trap_done));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "pc", pc_o, e_pc);
    chk(req, "priv", {30'd0, priv_o}, {30'd0, e_priv});
    chk(req, "status", status_o, e_status);
    chk(req, "sepc", sepc_o, e_sepc);
    chk(req, "scause", scause_o, e_scause);
    chk(req, "stval", stval_o, e_stval);
    chk(req, "mepc", mepc_o, e_mepc);
    chk(req, "mcause", mcause_o, e_mcause);
    chk(req, "mtval", mtval_o, e_mtval);
  endtask

  task automatic scramble();
    seed = nxt(seed); cur_pc = seed;
    seed = nxt(seed); trap_addr = seed;
    seed = nxt(seed); status_i = seed;
    seed = nxt(seed); mtvec_i = {seed[31:2], 2'b00};
    seed = nxt(seed); stvec_i = {seed[31:2], 2'b00};
  endtask

  task automatic do_trap(input logic [1:0] pv, input logic irq, input logic [4:0] code);
    logic [4:0] ec;
    logic [31:0] dl, cause;
    logic to_s, hit;
    @(negedge clk);
    scramble();
    cur_priv = pv; trap_is_irq = irq; trap_code = code; trap_valid = 1;
    // R3 correction, R4 mask choice, R5 routing, R2 cause layout
    ec = (!irq && code == 5'd8) ? 5'd8 + {3'd0, pv} : code;
    dl = irq ? mideleg_i : medeleg_i;
    to_s = (pv <= 2'd1) && dl[ec];
    cause = {irq, 26'd0, ec};
    // R8 address-carrying exception codes
    hit = !irq && (ec == 0 || ec == 1 || ec == 4 || ec == 5 || ec == 6 || ec == 7 ||
                   ec == 12 || ec == 13 || ec == 15);
    e_status = status_i; // R9
    if (to_s) begin // R6
      e_status[5] = status_i[1]; e_status[8] = pv[0]; e_status[1] = 1'b0;
      e_pc = stvec_i; e_priv = 2'd1; e_sepc = cur_pc; e_scause = cause;
      if (hit) e_stval = trap_addr;
    end else begin // R7
      e_status[7] = status_i[3]; e_status[12:11] = pv; e_status[3] = 1'b0;
      e_pc = mtvec_i; e_priv = 2'd3; e_mepc = cur_pc; e_mcause = cause;
      if (hit) e_mtval = trap_addr;
    end
    @(negedge clk);
    chk("R10", "done pulse", {31'd0, trap_done}, 32'd1);
    if (!irq && code == 5'd8) chk("R3", "ecall cause", to_s ? scause_o : mcause_o, cause);
    chk_all(to_s ? "R6" : "R7");
    trap_valid = 0;
    scramble(); // R10: inputs move while idle, nothing may change
    seed = nxt(seed); cur_priv = seed[1:0]; trap_code = seed[6:2]; trap_is_irq = seed[7];
    @(negedge clk);
    chk("R10", "done low", {31'd0, trap_done}, 32'd0);
    chk_all("R10");
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] pv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    e_pc = RST_PC; e_priv = 2'd3; e_status = '0;
    e_sepc = '0; e_scause = '0; e_stval = '0; e_mepc = '0; e_mcause = '0; e_mtval = '0;
    chk("R1", "done reset", {31'd0, trap_done}, 32'd0);
    chk_all("R1");
    for (int d = 0; d < 2; d++) begin
      medeleg_i = d[0] ? ~32'h8000_B3A5 : 32'h8000_B3A5;
      mideleg_i = d[0] ? ~32'h0000_4E2A : 32'h0000_4E2A;
      for (int p = 0; p < 3; p++) begin
        pv = (p == 2) ? 2'd3 : p[1:0];
        for (int irq = 0; irq < 2; irq++) begin
          for (int c = 0; c < 17; c++) begin
            do_trap(pv, irq[0], (c == 16) ? 5'd31 : c[4:0]);
          end
        end
      end
    end
    // R4: same code, interrupt vs exception, masks disagree on that bit
    medeleg_i = 32'h0000_0020; mideleg_i = 32'h0;
    do_trap(2'd0, 1'b0, 5'd5);
    chk("R4", "exc delegated", {30'd0, priv_o}, 32'd1);
    do_trap(2'd0, 1'b1, 5'd5);
    chk("R4", "irq not delegated", {30'd0, priv_o}, 32'd3);
    // R5: machine-mode trap ignores delegation
    medeleg_i = 32'hFFFF_FFFF;
    do_trap(2'd3, 1'b0, 5'd2);
    chk("R5", "M stays M", {30'd0, priv_o}, 32'd3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule